// File: doc/BRIEF.md
# Transmit Descriptor Chain Reader

This block is the fetch side of a transmit DMA path. Software builds a list of two-word descriptors in memory, loads the byte address of the first one into the queue-base register, and writes the control register with both the start bit and the enable bit set. The engine then walks the list. For each descriptor it reads the referenced buffer one 32-bit word at a time and sends its bytes on a ready/valid byte stream. Start-of-frame and end-of-frame markers bound each frame, and a frame may span several buffers.

When a frame has been sent, the engine rewrites the flag word of the frame's first descriptor with the used bit set, which returns that descriptor to software, and moves on to the next descriptor. The walk ends cleanly at a descriptor that software has left marked as used. The walk also ends on an error: the descriptors run out in the middle of a frame, or a buffer read is answered too slowly. In the error case the frame is closed by an error beat on the stream, and the cause is written into the first descriptor's flag word. When the walk ends, a sticky done bit in the status register is set, and software clears it by writing 1 to it.

The memory port is a request/acknowledge handshake. Each request is held until it is acknowledged, and read data is valid in the acknowledge cycle.

Top module: `tx_desc_reader`

## Requirements
- R1: After reset, `sts_rdata` is 0, `tx_valid` is 0 and `mem_req` is 0.
- R2: A control write starts a walk at the queue-base address only when the written word has bit 9 (start) and bit 3 (enable) both at 1. A write with bit 9 at 1 and bit 3 at 0 issues no memory request and leaves the status at 0.
- R3: A descriptor is word 0 at byte address A and word 1 at A+4. Word 0 is the buffer byte address, and its two low bits are ignored. Word 1 holds the byte length in bits 10:0 and marks the last buffer of a frame with bit 15. The bytes of each buffer word are sent lowest byte first.
- R4: The buffers of a frame are sent back to back. `tx_sof` marks the first byte of the frame, and `tx_eof` marks the final byte of the buffer whose bit 15 is set.
- R5: A descriptor with bit 31 (used) set, met at a frame boundary, is not sent. It ends the walk, and nothing is written to memory.
- R6: After a frame is sent, word 1 of the frame's first descriptor is written back with bit 31 set and its other bits unchanged. No other descriptor of that frame is written.
- R7: If bit 30 (wrap) is set in a descriptor, the next descriptor is fetched from the queue-base address. Otherwise the next descriptor is fetched from the current address plus 8.
- R8: If a used descriptor is met inside a frame, the engine sends one error beat (`tx_err`=1, `tx_eof`=1, data 0x00). It then writes back the first descriptor's word 1 with bits 31 and 27 set, and ends the walk.
- R9: If the acknowledge of a buffer-word read comes `STALL_LIMIT` or more cycles after the request, that word is not sent. The engine sends the error beat instead, with `tx_sof`=1 if no byte of the frame has been sent yet. It then writes back word 1 with bits 31 and 28 set, and ends the walk.
- R10: Status bit 5 (done) is set when a walk ends and stays set. Writing the status register with bit 5 at 1 clears it, and a write with bit 5 at 0 leaves it set.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, the data and marker outputs hold still.
- R12: A memory request holds its address, write enable and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word (bit 9 start, bit 3 enable) |
| qbase_we | input | 1 | Queue-base register write strobe |
| qbase_wdata | input | ADDR_W | Byte address of the first descriptor |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data; 1 in bit 5 clears done |
| sts_rdata | output | 32 | Status; bit 5 is done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request acknowledge; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Final beat of frame |
| tx_err | output | 1 | Frame aborted on this beat |

## Verification
The byte stream is due one cycle after each buffer-word acknowledge and then advances by one byte per accepted handshake. The monitor therefore compares beats only in cycles where `tx_valid` and `tx_ready` are both high, sampling at the falling edge, against a queue the driver filled when it built the descriptors. Write-backs and the done bit follow the acknowledge of the last read or write by one cycle. The bench waits for done before it inspects memory, so the timing of the slow-memory cases does not matter. For the ignored start, the bench watches `mem_req` for a fixed window, and for the status clear it reads the register one cycle after the write.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int unsigned LEN_W    = 11;
  localparam int unsigned B_LAST   = 15;
  localparam int unsigned B_EXH    = 27;
  localparam int unsigned B_UND    = 28;
  localparam int unsigned B_WRAP   = 30;
  localparam int unsigned B_USED   = 31;
  localparam int unsigned CTL_EN   = 3;
  localparam int unsigned CTL_GO   = 9;
  localparam int unsigned STS_DONE = 5;

  typedef enum logic [2:0] {
    W_IDLE, W_RD0, W_RD1, W_RDD, W_SEND, W_ERR, W_WB
  } walk_e;

  // bytes carried by the next buffer word
  function automatic logic [2:0] beat_bytes(input logic [LEN_W-1:0] left);
    return (left >= LEN_W'(4)) ? 3'd4 : left[2:0];
  endfunction

  // flag word returned to software for the first descriptor of a frame
  function automatic logic [31:0] wb_word(input logic [31:0] w1,
                                          input logic exh, input logic und);
    logic [31:0] r;
    r = w1;
    r[B_USED] = 1'b1;
    r[B_EXH]  = w1[B_EXH] | exh;
    r[B_UND]  = w1[B_UND] | und;
    return r;
  endfunction
endpackage

// File: rtl/tdr_regs.sv
module tdr_regs #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  input  logic              qbase_we,
  input  logic [ADDR_W-1:0] qbase_wdata,
  input  logic              sts_we,
  input  logic [31:0]       sts_wdata,
  input  logic              busy,
  input  logic              walk_end,
  output logic              go,
  output logic [ADDR_W-1:0] qbase,
  output logic [31:0]       sts_rdata
);
  import tdr_pkg::*;

  logic done_q;
  logic unused_wbits;

  assign unused_wbits = ^{ctl_wdata, sts_wdata};
  assign go = ctl_we & ctl_wdata[CTL_GO] & ctl_wdata[CTL_EN] & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qbase  <= '0;
      done_q <= 1'b0;
    end else begin
      if (qbase_we) qbase <= qbase_wdata;
      if (walk_end) done_q <= 1'b1;
      else if (sts_we && sts_wdata[STS_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    sts_rdata = '0;
    sts_rdata[STS_DONE] = done_q;
  end

  // R10: done is sticky unless cleared by a write of 1
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(sts_we && sts_wdata[STS_DONE])) |=> done_q);
endmodule

// File: rtl/tdr_ser.sv
module tdr_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_word,
  input  logic [2:0]  ld_cnt,
  input  logic        ld_sof,
  input  logic        ld_eof,
  input  logic        ld_err,
  output logic        drained,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic        tx_err
);
  logic [31:0] sh;
  logic [2:0]  cnt;
  logic        sof_f, eof_f, err_f;
  logic        fire;

  assign tx_valid = (cnt != 3'd0);
  assign fire     = tx_valid & tx_ready;
  assign tx_data  = sh[7:0];
  assign tx_sof   = sof_f;
  assign tx_eof   = eof_f & (cnt == 3'd1);
  assign tx_err   = err_f & (cnt == 3'd1);
  assign drained  = fire & (cnt == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; sof_f <= 1'b0; eof_f <= 1'b0; err_f <= 1'b0;
    end else if (ld) begin
      sh <= ld_word; cnt <= ld_cnt;
      sof_f <= ld_sof; eof_f <= ld_eof; err_f <= ld_err;
    end else if (fire) begin
      sh    <= {8'd0, sh[31:8]};
      cnt   <= cnt - 3'd1;
      sof_f <= 1'b0;
    end
  end

  // R11: beat held stable under backpressure
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof)
                                  && $stable(tx_eof) && $stable(tx_err)));
  // R8: an error beat always closes the frame with a zero byte
  a_r8_err_closes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (tx_eof && tx_data == 8'd0));
  // loads only land on an empty serializer
  a_r4_load_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !tx_valid);
endmodule

// File: rtl/tdr_walk.sv
module tdr_walk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned STALL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] qbase,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              drained,
  output logic              ld,
  output logic [31:0]       ld_word,
  output logic [2:0]        ld_cnt,
  output logic              ld_sof,
  output logic              ld_eof,
  output logic              ld_err,
  output logic              walk_end,
  output logic              busy
);
  import tdr_pkg::*;

  localparam int unsigned SC_W = $clog2(STALL_LIMIT + 1);
  localparam logic [SC_W-1:0] STALL_MAX = SC_W'(STALL_LIMIT);

  walk_e             st;
  logic [ADDR_W-1:0] cur, nxt, first, dptr;
  logic [31:0]       first_w1;
  logic [LEN_W-1:0]  left;
  logic              last_f, in_frame, sof_pend, exh, und, err_f;
  logic [SC_W-1:0]   stall;
  logic              und_now, rd1_used, data_ok;

  assign und_now  = (stall == STALL_MAX);
  assign rd1_used = (st == W_RD1) && mem_ack && mem_rdata[B_USED];
  assign data_ok  = (st == W_RDD) && mem_ack && !und_now;
  assign walk_end = (rd1_used && !in_frame) || ((st == W_WB) && mem_ack && err_f);
  assign busy     = (st != W_IDLE);

  assign mem_req   = (st == W_RD0) || (st == W_RD1) || (st == W_RDD) || (st == W_WB);
  assign mem_we    = (st == W_WB);
  assign mem_wdata = wb_word(first_w1, exh, und);

  always_comb begin
    case (st)
      W_RD1:   mem_addr = cur + ADDR_W'(4);
      W_RDD:   mem_addr = {dptr[ADDR_W-1:2], 2'b00};
      W_WB:    mem_addr = first + ADDR_W'(4);
      default: mem_addr = cur;
    endcase
  end

  always_comb begin
    ld      = data_ok || (st == W_ERR);
    ld_word = (st == W_ERR) ? 32'd0 : mem_rdata;
    ld_cnt  = (st == W_ERR) ? 3'd1 : beat_bytes(left);
    ld_sof  = sof_pend;
    ld_eof  = (st == W_ERR) ? 1'b1 : (last_f && (left <= LEN_W'(4)));
    ld_err  = (st == W_ERR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; cur <= '0; nxt <= '0; first <= '0; dptr <= '0;
      first_w1 <= '0; left <= '0; last_f <= 1'b0; in_frame <= 1'b0;
      sof_pend <= 1'b0; exh <= 1'b0; und <= 1'b0; err_f <= 1'b0; stall <= '0;
    end else begin
      case (st)
        W_IDLE: if (go) begin
          cur <= qbase; in_frame <= 1'b0;
          exh <= 1'b0; und <= 1'b0; err_f <= 1'b0;
          st <= W_RD0;
        end
        W_RD0: if (mem_ack) begin
          dptr <= {mem_rdata[ADDR_W-1:2], 2'b00};
          st   <= W_RD1;
        end
        W_RD1: if (mem_ack) begin
          if (mem_rdata[B_USED]) begin
            if (in_frame) begin exh <= 1'b1; st <= W_ERR; end
            else st <= W_IDLE;
          end else begin
            nxt    <= mem_rdata[B_WRAP] ? qbase : cur + ADDR_W'(8);
            left   <= mem_rdata[LEN_W-1:0];
            last_f <= mem_rdata[B_LAST];
            stall  <= '0;
            if (!in_frame) begin
              first <= cur; first_w1 <= mem_rdata;
              in_frame <= 1'b1; sof_pend <= 1'b1;
            end
            st <= W_RDD;
          end
        end
        W_RDD: begin
          if (mem_ack) begin
            stall <= '0;
            if (und_now) begin
              und <= 1'b1; st <= W_ERR;
            end else begin
              left     <= left - LEN_W'(beat_bytes(left));
              dptr     <= dptr + ADDR_W'(4);
              sof_pend <= 1'b0;
              st       <= W_SEND;
            end
          end else if (!und_now) begin
            stall <= stall + SC_W'(1);
          end
        end
        W_ERR: begin
          err_f <= 1'b1; sof_pend <= 1'b0; st <= W_SEND;
        end
        W_SEND: if (drained) begin
          if (err_f) st <= W_WB;
          else if (left == '0) begin
            if (last_f) st <= W_WB;
            else begin cur <= nxt; st <= W_RD0; end
          end else st <= W_RDD;
        end
        W_WB: if (mem_ack) begin
          in_frame <= 1'b0;
          if (err_f) st <= W_IDLE;
          else begin cur <= nxt; st <= W_RD0; end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R12: request held steady until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R6: every write-back hands the descriptor to software
  a_r6_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_USED]);
  // R2: a start fetches from the queue base
  a_r2_start_base: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (mem_req && !mem_we && mem_addr == $past(qbase)));
  // R8/R9: an error-flagged write-back only follows an error beat
  a_r8_flag_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_wdata[B_EXH] != first_w1[B_EXH] ||
                           mem_wdata[B_UND] != first_w1[B_UND])) |-> err_f);
endmodule

// File: rtl/tx_desc_reader.sv
module tx_desc_reader #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned STALL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  input  logic              qbase_we,
  input  logic [ADDR_W-1:0] qbase_wdata,
  input  logic              sts_we,
  input  logic [31:0]       sts_wdata,
  output logic [31:0]       sts_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_err
);
  logic              go, busy, walk_end, drained;
  logic [ADDR_W-1:0] qbase;
  logic              ld, ld_sof, ld_eof, ld_err;
  logic [31:0]       ld_word;
  logic [2:0]        ld_cnt;

  tdr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .qbase_we(qbase_we), .qbase_wdata(qbase_wdata), .sts_we(sts_we),
    .sts_wdata(sts_wdata), .busy(busy), .walk_end(walk_end), .go(go),
    .qbase(qbase), .sts_rdata(sts_rdata));

  tdr_walk #(.ADDR_W(ADDR_W), .STALL_LIMIT(STALL_LIMIT)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .qbase(qbase), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .drained(drained), .ld(ld),
    .ld_word(ld_word), .ld_cnt(ld_cnt), .ld_sof(ld_sof), .ld_eof(ld_eof),
    .ld_err(ld_err), .walk_end(walk_end), .busy(busy));

  tdr_ser u_ser (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(ld_word), .ld_cnt(ld_cnt),
    .ld_sof(ld_sof), .ld_eof(ld_eof), .ld_err(ld_err), .drained(drained),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_err(tx_err));

  // R1: nothing moves before a start
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));
endmodule

// File: tb/tx_desc_reader_test.sv
module tx_desc_reader_test;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam logic [31:0] USED = 32'h8000_0000, WRAP = 32'h4000_0000;
  localparam logic [31:0] LAST = 32'h0000_8000, EXH = 32'h0800_0000, UND = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, qbase_we = 0, sts_we = 0;
  logic [31:0] ctl_wdata = 0, sts_wdata = 0, sts_rdata;
  logic [AW-1:0] qbase_wdata = 0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, tx_sof, tx_eof, tx_err;
  logic [7:0] tx_data;

  logic [31:0] mem [0:1023];
  int lat = 1, wcnt = 0, wr_cnt = 0, bp = 0;
  bit req_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [10:0] exp_q[$];
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_desc_reader #(.ADDR_W(AW), .STALL_LIMIT(16)) uut (.*);

  // memory model: acknowledges lat cycles after a request appears
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_rdata <= 0; wcnt <= 0;
    end else begin
      mem_ack <= 0;
      if (mem_req) req_seen <= 1;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          mem_ack <= 1; wcnt <= 0;
          mem_rdata <= mem[mem_addr[11:2]];
          if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= (bp == 0) ? 1'b1 : lfsr[0];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      logic [10:0] got, e;
      got = {tx_err, tx_eof, tx_sof, tx_data};
      if (exp_q.size() == 0) check(0, "R4 unexpected beat", {21'd0, got}, 32'hFFFF_FFFF);
      else begin
        e = exp_q.pop_front();
        check(got == e, "R3/R4/R11 beat {err,eof,sof,data}", {21'd0, got}, {21'd0, e});
      end
    end
  end

  task automatic reg_ctl(input logic [31:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d; @(negedge clk); ctl_we = 0;
  endtask
  task automatic reg_qbase(input logic [AW-1:0] a);
    @(negedge clk); qbase_we = 1; qbase_wdata = a; @(negedge clk); qbase_we = 0;
  endtask
  task automatic reg_sts(input logic [31:0] d);
    @(negedge clk); sts_we = 1; sts_wdata = d; @(negedge clk); sts_we = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a >> 2] = w0; mem[(a >> 2) + 1] = w1;
  endtask

  // fills a buffer and queues the beats it should produce
  task automatic add_buf(input int a, input int len, input int seed, input bit sof, input bit eof);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed + i);
      mem[(a + i) >> 2][8*((a + i) % 4) +: 8] = b;
      exp_q.push_back({1'b0, eof && (i == len - 1), sof && (i == 0), b});
    end
  endtask

  task automatic run_walk(input logic [AW-1:0] base, input string tag);
    int n;
    wr_cnt = 0;
    reg_qbase(base);
    reg_ctl(32'h0000_0208);
    n = 0;
    while (!sts_rdata[5] && n < 5000) begin @(negedge clk); n++; end
    check(sts_rdata == 32'h20, {tag, " R10 done set"}, sts_rdata, 32'h20);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R4 all beats seen"}, exp_q.size(), 0);
    exp_q.delete();
    reg_sts(32'h20);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(sts_rdata == 0 && !tx_valid && !mem_req, "R1 reset outputs",
          {sts_rdata[31:2], tx_valid, mem_req}, 0);

    // R2 start without enable is ignored
    req_seen = 0;
    reg_ctl(32'h0000_0200);
    repeat (20) @(negedge clk);
    check(!req_seen, "R2 start without enable, mem_req", {31'd0, req_seen}, 0);
    check(sts_rdata == 0, "R2 start without enable, status", sts_rdata, 0);

    // single-buffer frame
    put_desc(32'h100, 32'h400, LAST | 6);
    put_desc(32'h108, 0, USED);
    add_buf(32'h400, 6, 8'h10, 1, 1);
    run_walk(16'h100, "single");
    check(mem[32'h104 >> 2] == (USED | LAST | 6), "R6 single write-back", mem[32'h104 >> 2], USED | LAST | 6);
    check(mem[32'h10C >> 2] == USED, "R5 stop descriptor untouched", mem[32'h10C >> 2], USED);
    check(wr_cnt == 1, "R6 single write count", wr_cnt, 1);

    // R10 done clear semantics
    reg_qbase(16'h108);
    reg_ctl(32'h0000_0208);
    repeat (20) @(negedge clk);
    reg_sts(32'h0);
    check(sts_rdata[5], "R10 write 0 keeps done", sts_rdata, 32'h20);
    reg_sts(32'h20);
    check(sts_rdata == 0, "R10 write 1 clears done", sts_rdata, 0);

    // multi-buffer frame under backpressure, misaligned address bits
    bp = 1;
    put_desc(32'h200, 32'h500, 5);
    put_desc(32'h208, 32'h602, 4);
    put_desc(32'h210, 32'h700, LAST | 3);
    put_desc(32'h218, 0, USED);
    add_buf(32'h500, 5, 8'h20, 1, 0);
    add_buf(32'h600, 4, 8'h40, 0, 0);
    add_buf(32'h700, 3, 8'h60, 0, 1);
    run_walk(16'h200, "multi R11");
    check(mem[32'h204 >> 2] == (USED | 5), "R6 multi first write-back", mem[32'h204 >> 2], USED | 5);
    check(mem[32'h20C >> 2] == 4, "R6 middle untouched", mem[32'h20C >> 2], 4);
    check(mem[32'h214 >> 2] == (LAST | 3), "R6 last untouched", mem[32'h214 >> 2], LAST | 3);

    // two frames back to back
    bp = 0;
    put_desc(32'h300, 32'h800, LAST | 4);
    put_desc(32'h308, 32'h880, LAST | 7);
    put_desc(32'h310, 0, USED);
    add_buf(32'h800, 4, 8'h80, 1, 1);
    add_buf(32'h880, 7, 8'h90, 1, 1);
    run_walk(16'h300, "two frames");
    check(mem[32'h304 >> 2] == (USED | LAST | 4), "R6 frame A write-back", mem[32'h304 >> 2], USED | LAST | 4);
    check(mem[32'h30C >> 2] == (USED | LAST | 7), "R6 frame B write-back", mem[32'h30C >> 2], USED | LAST | 7);
    check(wr_cnt == 2, "R6 two-frame write count", wr_cnt, 2);

    // wrap: single descriptor returns to base, now used, so stops
    put_desc(32'h380, 32'h900, WRAP | LAST | 9);
    put_desc(32'h388, 32'h980, LAST | 3);
    add_buf(32'h900, 9, 8'hA0, 1, 1);
    run_walk(16'h380, "R7 wrap");
    check(mem[32'h384 >> 2] == (USED | WRAP | LAST | 9), "R7 wrap write-back", mem[32'h384 >> 2], USED | WRAP | LAST | 9);
    check(mem[32'h38C >> 2] == (LAST | 3), "R7 next slot never fetched", mem[32'h38C >> 2], LAST | 3);

    // exhaustion mid-frame
    put_desc(32'h180, 32'hA00, 3);
    put_desc(32'h188, 0, USED);
    add_buf(32'hA00, 3, 8'hB0, 1, 0);
    exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
    run_walk(16'h180, "R8 exhausted");
    check(mem[32'h184 >> 2] == (USED | EXH | 3), "R8 exhausted write-back", mem[32'h184 >> 2], USED | EXH | 3);

    // underrun on slow buffer read; descriptor reads still complete (R12)
    lat = 40;
    put_desc(32'h1C0, 32'hB00, LAST | 4);
    put_desc(32'h1C8, 0, USED);
    mem[32'hB00 >> 2] = 32'h1234_5678;
    exp_q.push_back({1'b1, 1'b1, 1'b1, 8'h00});
    run_walk(16'h1C0, "R9 underrun");
    check(mem[32'h1C4 >> 2] == (USED | UND | LAST | 4), "R9/R12 underrun write-back", mem[32'h1C4 >> 2], USED | UND | LAST | 4);
    lat = 1;

    // used descriptor at the start: nothing sent, nothing written
    put_desc(32'h1E0, 32'hC00, USED | LAST | 5);
    run_walk(16'h1E0, "R5 used at start");
    check(wr_cnt == 0, "R5 no write-back", wr_cnt, 0);
    check(mem[32'h1E4 >> 2] == (USED | LAST | 5), "R5 descriptor unchanged", mem[32'h1E4 >> 2], USED | LAST | 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule